// File: doc/BRIEF.md
# Cache-Block Zeroing Engine

This block carries out a whole-block zero store. A requester hands it a register address and a block-size exponent N, where the block is 2^N bytes. The engine first checks that the operation is allowed at the current privilege level and that N is in range. It then rounds the address down to the start of the enclosing block and clears the block one bus word at a time, going through a simple write request and response channel.

Before each word is written, the engine asks an external address-check port whether the write is allowed. It finishes with a one-cycle `done` pulse. If the operation is refused, or the permission check or the memory reports a failure, it finishes instead with a one-cycle `err` pulse, an error code, and the unaligned address it was started with.

Writes always go to whole, aligned bus words in ascending order. A block narrower than the bus is cleared by one write whose byte strobe covers only the block's own lanes.

Top module: `blkzero_engine`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done`, `err`, `wr_valid` and `xl_req_valid` are low and `start_ready` is high.
- R2: Privilege is encoded as 2'b11 machine, 2'b01 supervisor and 2'b00 user, with 2'b10 reserved. The start is allowed as follows:
  - machine: always allowed;
  - supervisor: allowed only when `menv_zero_en` is 1;
  - user: allowed only when `menv_zero_en` is 1 and either `smode_impl` is 0 or `senv_zero_en` is 1;
  - reserved: never allowed.
  A refused start gives `err` with `err_code` 1 and issues no check and no write. This test takes priority over R3.
- R3: An allowed start whose exponent is above 12 gives `err` with `err_code` 3'd2 and issues no write.
- R4: The first write goes to the address obtained by clearing the low N bits of `start_addr` and then the low 2 bits (the word offset on a 32-bit bus).
- R5: For N >= 2 the engine issues 2^(N-2) writes to consecutive ascending word addresses. Every write carries all-zero data and `wr_strb` = 4'b1111, so every byte of the block becomes zero. The engine then pulses `done`.
- R6: For N < 2 the engine issues exactly one write. Its strobe has 2^N set bits, starting at lane = aligned address bits [1:0]. No byte outside the block changes.
- R7: Every write is preceded by a check on `xl_req_addr`. A check answered with `xl_rsp_fault` = 1 ends the operation before that word is written, with `err_code` 3'd3 and `err_addr` equal to the unaligned `start_addr`.
- R8: A write answered with `wr_rsp_err` = 1 ends the operation with `err_code` 3'd4 and `err_addr` equal to the unaligned `start_addr`. No further check or write follows.
- R9: A start is accepted when `start_valid` and `start_ready` are both high.
  - `busy` is high from the cycle after acceptance until the cycle of the ending pulse, and `start_ready` is its inverse.
  - A `start_valid` raised while busy is ignored.
  - No request is issued while idle.
- R10: Each accepted start ends with exactly one single-cycle pulse, either `done` or `err`, never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Engine idle, start can be taken |
| start_addr | input | ADDR_W | Register address, possibly unaligned |
| start_exp | input | EXP_W | Block-size exponent N |
| priv | input | 2 | Current privilege level |
| menv_zero_en | input | 1 | Machine-level enable for lower levels |
| senv_zero_en | input | 1 | Supervisor-level enable for user level |
| smode_impl | input | 1 | Supervisor level exists |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Failure pulse |
| err_code | output | 3 | Failure cause, valid with `err` |
| err_addr | output | ADDR_W | Unaligned start address, valid with `err` |
| xl_req_valid | output | 1 | Permission check request |
| xl_req_addr | output | ADDR_W | Word address being checked |
| xl_rsp_valid | input | 1 | Permission check answer |
| xl_rsp_fault | input | 1 | Write not permitted |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write request taken |
| wr_addr | output | ADDR_W | Aligned word address |
| wr_data | output | DATA_W | Write data (zero) |
| wr_strb | output | DATA_W/8 | Byte strobes |
| wr_rsp_valid | input | 1 | Write response |
| wr_rsp_err | input | 1 | Write failed |

## Verification
The bench builds the engine with its defaults: a 32-bit address, a 32-bit data bus and a maximum exponent of 12. With a four-byte word, exponents 0 and 1 exercise the partial-strobe path and exponent 2 gives a block of exactly one word. Exponent 12 runs the full 1024-word sweep through the counter, and exponents 13 and 14 fall just past the legal range. A 16 KiB byte model behind the write port shows that each block lands exactly, with no byte disturbed on either side, and the permission and memory responders inject failures at chosen word indices partway through a block.

// File: rtl/cbz_pkg.sv
package cbz_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_WRITE = 2'd2,
      ST_RESP  = 2'd3
   } cbz_state_e;

   typedef enum logic [2:0] {
      ERR_NONE    = 3'd0,
      ERR_ILLEGAL = 3'd1,
      ERR_BAD_EXP = 3'd2,
      ERR_XLATE   = 3'd3,
      ERR_MEM     = 3'd4
   } cbz_err_e;

   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_S = 2'b01;
   localparam logic [1:0] PRIV_M = 2'b11;

endpackage

// File: rtl/cbz_priv_gate.sv
module cbz_priv_gate
   import cbz_pkg::*;
(
   input  logic [1:0] priv_i,
   input  logic       m_en_i,
   input  logic       s_en_i,
   input  logic       smode_impl_i,
   output logic       allow_o
);

   always_comb begin
      case (priv_i)
         PRIV_M:  allow_o = 1'b1;
         PRIV_S:  allow_o = m_en_i;
         PRIV_U:  allow_o = m_en_i & (~smode_impl_i | s_en_i);
         default: allow_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/cbz_span.sv
module cbz_span #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int EXP_W   = 4,
   parameter int MAX_EXP = 12,
   localparam int BYTES  = DATA_W / 8,
   localparam int OFF_W  = $clog2(BYTES),
   localparam int CNT_W  = MAX_EXP + 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [EXP_W-1:0]  exp_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [CNT_W-1:0]  cnt_m1_o,
   output logic [BYTES-1:0]  strb_o
);

   localparam int LO_W = (OFF_W > 0) ? OFF_W : 1;

   logic [ADDR_W-1:0] blk_mask;
   logic [ADDR_W-1:0] aligned;
   logic [LO_W-1:0]   lane_off;

   assign blk_mask = (ADDR_W'(1) << exp_i) - ADDR_W'(1);
   assign aligned  = addr_i & ~blk_mask;

   generate
      if (OFF_W > 0) begin : g_wide_bus
         assign lane_off = aligned[LO_W-1:0];
         assign base_o   = {aligned[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end else begin : g_byte_bus
         assign lane_off = '0;
         assign base_o   = aligned;
      end
   endgenerate

   always_comb begin
      int e;
      logic [CNT_W-1:0] cnt;
      logic [BYTES-1:0] lanes;
      e     = int'(exp_i);
      cnt   = '0;
      lanes = '0;
      if (e >= OFF_W) begin
         cnt      = CNT_W'(1) << (e - OFF_W);
         cnt_m1_o = cnt - CNT_W'(1);
         strb_o   = '1;
      end else begin
         lanes    = (BYTES'(1) << (1 << e)) - BYTES'(1);
         cnt_m1_o = '0;
         strb_o   = lanes << lane_off;
      end
   end

endmodule

// File: rtl/cbz_seq.sv
module cbz_seq
   import cbz_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 13,
   localparam int BYTES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_fire_i,
   input  logic              allow_i,
   input  logic              exp_ok_i,
   input  logic [ADDR_W-1:0] orig_addr_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  cnt_m1_i,
   input  logic [BYTES-1:0]  strb_i,
   output logic              xl_req_valid_o,
   output logic [ADDR_W-1:0] xl_req_addr_o,
   input  logic              xl_rsp_valid_i,
   input  logic              xl_rsp_fault_i,
   output logic              wr_valid_o,
   input  logic              wr_ready_i,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [BYTES-1:0]  wr_strb_o,
   input  logic              wr_rsp_valid_i,
   input  logic              wr_rsp_err_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [2:0]        err_code_o,
   output logic [ADDR_W-1:0] err_addr_o
);

   cbz_state_e        state_q;
   cbz_err_e          code_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] orig_q;
   logic [CNT_W-1:0]  remain_q;
   logic [BYTES-1:0]  strb_q;
   logic              done_q;
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         code_q   <= ERR_NONE;
         cur_q    <= '0;
         orig_q   <= '0;
         remain_q <= '0;
         strb_q   <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_fire_i) begin
                  orig_q <= orig_addr_i;
                  if (!allow_i) begin
                     err_q  <= 1'b1;
                     code_q <= ERR_ILLEGAL;
                  end else if (!exp_ok_i) begin
                     err_q  <= 1'b1;
                     code_q <= ERR_BAD_EXP;
                  end else begin
                     cur_q    <= base_i;
                     remain_q <= cnt_m1_i;
                     strb_q   <= strb_i;
                     state_q  <= ST_CHECK;
                  end
               end
            end
            ST_CHECK: begin
               if (xl_rsp_valid_i) begin
                  if (xl_rsp_fault_i) begin
                     err_q   <= 1'b1;
                     code_q  <= ERR_XLATE;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_WRITE;
                  end
               end
            end
            ST_WRITE: begin
               if (wr_ready_i) state_q <= ST_RESP;
            end
            ST_RESP: begin
               if (wr_rsp_valid_i) begin
                  if (wr_rsp_err_i) begin
                     err_q   <= 1'b1;
                     code_q  <= ERR_MEM;
                     state_q <= ST_IDLE;
                  end else if (remain_q == '0) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     cur_q    <= cur_q + ADDR_W'(BYTES);
                     remain_q <= remain_q - CNT_W'(1);
                     state_q  <= ST_CHECK;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign xl_req_valid_o = (state_q == ST_CHECK);
   assign xl_req_addr_o  = cur_q;
   assign wr_valid_o     = (state_q == ST_WRITE);
   assign wr_addr_o      = cur_q;
   assign wr_data_o      = '0;
   assign wr_strb_o      = strb_q;
   assign busy_o         = (state_q != ST_IDLE);
   assign done_o         = done_q;
   assign err_o          = err_q;
   assign err_code_o     = err_q ? code_q : ERR_NONE;
   assign err_addr_o     = orig_q;

endmodule

// File: rtl/blkzero_engine.sv
module blkzero_engine #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int MAX_EXP = 12,
   parameter int EXP_W   = 4,
   localparam int BYTES  = DATA_W / 8,
   localparam int CNT_W  = MAX_EXP + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_valid,
   output logic              start_ready,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [EXP_W-1:0]  start_exp,
   input  logic [1:0]        priv,
   input  logic              menv_zero_en,
   input  logic              senv_zero_en,
   input  logic              smode_impl,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [2:0]        err_code,
   output logic [ADDR_W-1:0] err_addr,
   output logic              xl_req_valid,
   output logic [ADDR_W-1:0] xl_req_addr,
   input  logic              xl_rsp_valid,
   input  logic              xl_rsp_fault,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [BYTES-1:0]  wr_strb,
   input  logic              wr_rsp_valid,
   input  logic              wr_rsp_err
);

   generate
      if ((DATA_W % 8) != 0 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_data_w
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if (MAX_EXP >= ADDR_W) begin : g_bad_max_exp
         $error("MAX_EXP must be below ADDR_W");
      end
      if ((2 ** EXP_W) <= MAX_EXP) begin : g_bad_exp_w
         $error("EXP_W too narrow for MAX_EXP");
      end
   endgenerate

   logic              allow;
   logic              exp_ok;
   logic              start_fire;
   logic [ADDR_W-1:0] span_base;
   logic [CNT_W-1:0]  span_cnt_m1;
   logic [BYTES-1:0]  span_strb;

   assign start_ready = ~busy;
   assign start_fire  = start_valid & start_ready;
   assign exp_ok      = (int'(start_exp) <= MAX_EXP);

   cbz_priv_gate u_gate (
      .priv_i       (priv),
      .m_en_i       (menv_zero_en),
      .s_en_i       (senv_zero_en),
      .smode_impl_i (smode_impl),
      .allow_o      (allow)
   );

   cbz_span #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .EXP_W   (EXP_W),
      .MAX_EXP (MAX_EXP)
   ) u_span (
      .addr_i   (start_addr),
      .exp_i    (start_exp),
      .base_o   (span_base),
      .cnt_m1_o (span_cnt_m1),
      .strb_o   (span_strb)
   );

   cbz_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_fire_i   (start_fire),
      .allow_i        (allow),
      .exp_ok_i       (exp_ok),
      .orig_addr_i    (start_addr),
      .base_i         (span_base),
      .cnt_m1_i       (span_cnt_m1),
      .strb_i         (span_strb),
      .xl_req_valid_o (xl_req_valid),
      .xl_req_addr_o  (xl_req_addr),
      .xl_rsp_valid_i (xl_rsp_valid),
      .xl_rsp_fault_i (xl_rsp_fault),
      .wr_valid_o     (wr_valid),
      .wr_ready_i     (wr_ready),
      .wr_addr_o      (wr_addr),
      .wr_data_o      (wr_data),
      .wr_strb_o      (wr_strb),
      .wr_rsp_valid_i (wr_rsp_valid),
      .wr_rsp_err_i   (wr_rsp_err),
      .busy_o         (busy),
      .done_o         (done),
      .err_o          (err),
      .err_code_o     (err_code),
      .err_addr_o     (err_addr)
   );

endmodule

// File: rtl/cbz_checker.sv
module cbz_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_valid,
   input logic              start_ready,
   input logic [ADDR_W-1:0] start_addr,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [ADDR_W-1:0] err_addr,
   input logic              xl_req_valid,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [BYTES-1:0]  wr_strb
);

   logic [ADDR_W-1:0] cap_addr;
   logic [ADDR_W-1:0] prev_addr;
   logic              have_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr  <= '0;
         prev_addr <= '0;
         have_prev <= 1'b0;
      end else begin
         if (start_valid && start_ready) begin
            cap_addr  <= start_addr;
            have_prev <= 1'b0;
         end else if (wr_valid && wr_ready) begin
            prev_addr <= wr_addr;
            have_prev <= 1'b1;
         end
      end
   end

   a_r10_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_valid));

   a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!wr_valid && !xl_req_valid));

   a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ((wr_addr & ADDR_W'(BYTES - 1)) == '0));

   a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && have_prev) |-> (wr_addr == prev_addr + ADDR_W'(BYTES)));

   a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_strb)));

   a_r7_err_addr_orig: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (err_addr == cap_addr));

   a_r8_stop_after_err: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!wr_valid && !xl_req_valid));

endmodule

bind blkzero_engine cbz_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_cbz_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_valid  (start_valid),
   .start_ready  (start_ready),
   .start_addr   (start_addr),
   .busy         (busy),
   .done         (done),
   .err          (err),
   .err_addr     (err_addr),
   .xl_req_valid (xl_req_valid),
   .wr_valid     (wr_valid),
   .wr_ready     (wr_ready),
   .wr_addr      (wr_addr),
   .wr_strb      (wr_strb)
);

// File: tb/tb_blkzero_engine.sv
module tb_blkzero_engine;

   localparam int AW    = 32;
   localparam int DW    = 32;
   localparam int NB    = DW / 8;
   localparam int MEMSZ = 16384;

   typedef struct packed {
      logic [31:0] addr;
      logic [3:0]  e;
      logic [1:0]  pv;
      logic        men;
      logic        sen;
      logic        smi;
      int          fault_at;
      int          merr_at;
      logic [2:0]  code;
      int          nwr;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{32'h2047, 4'd6,  2'b11, 1'b0, 1'b0, 1'b1, -1, -1, 3'd0, 16},
      '{32'h2103, 4'd0,  2'b01, 1'b1, 1'b0, 1'b1, -1, -1, 3'd0, 1},
      '{32'h2206, 4'd1,  2'b00, 1'b1, 1'b1, 1'b1, -1, -1, 3'd0, 1},
      '{32'h230A, 4'd2,  2'b00, 1'b1, 1'b0, 1'b0, -1, -1, 3'd0, 1},
      '{32'h2411, 4'd3,  2'b01, 1'b0, 1'b1, 1'b1, -1, -1, 3'd1, 0},
      '{32'h2500, 4'd6,  2'b00, 1'b1, 1'b0, 1'b1, -1, -1, 3'd1, 0},
      '{32'h2500, 4'd6,  2'b00, 1'b0, 1'b1, 1'b0, -1, -1, 3'd1, 0},
      '{32'h2600, 4'd13, 2'b11, 1'b0, 1'b0, 1'b0, -1, -1, 3'd2, 0},
      '{32'h2A35, 4'd5,  2'b11, 1'b0, 1'b0, 1'b0,  3, -1, 3'd3, 3},
      '{32'h2B7F, 4'd7,  2'b11, 1'b0, 1'b0, 1'b0, -1,  5, 3'd4, 6},
      '{32'h3ABC, 4'd12, 2'b11, 1'b0, 1'b0, 1'b0, -1, -1, 3'd0, 1024},
      '{32'h2C00, 4'd4,  2'b01, 1'b1, 1'b0, 1'b1, -1, -1, 3'd0, 4},
      '{32'h2D00, 4'd6,  2'b10, 1'b1, 1'b1, 1'b1, -1, -1, 3'd1, 0},
      '{32'h2E00, 4'd14, 2'b00, 1'b0, 1'b1, 1'b1, -1, -1, 3'd1, 0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_valid = 1'b0;
   logic          start_ready;
   logic [AW-1:0] start_addr = '0;
   logic [3:0]    start_exp = '0;
   logic [1:0]    priv = 2'b11;
   logic          menv_zero_en = 1'b0;
   logic          senv_zero_en = 1'b0;
   logic          smode_impl = 1'b0;
   logic          busy, done, err;
   logic [2:0]    err_code;
   logic [AW-1:0] err_addr;
   logic          xl_req_valid;
   logic [AW-1:0] xl_req_addr;
   logic          xl_rsp_valid = 1'b0;
   logic          xl_rsp_fault = 1'b0;
   logic          wr_valid;
   logic          wr_ready = 1'b0;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [NB-1:0] wr_strb;
   logic          wr_rsp_valid = 1'b1;
   logic          wr_rsp_err = 1'b0;

   always #10 clk = ~clk;

   blkzero_engine dut (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_ready(start_ready),
      .start_addr(start_addr), .start_exp(start_exp), .priv(priv),
      .menv_zero_en(menv_zero_en), .senv_zero_en(senv_zero_en), .smode_impl(smode_impl),
      .busy(busy), .done(done), .err(err), .err_code(err_code), .err_addr(err_addr),
      .xl_req_valid(xl_req_valid), .xl_req_addr(xl_req_addr),
      .xl_rsp_valid(xl_rsp_valid), .xl_rsp_fault(xl_rsp_fault),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_strb(wr_strb),
      .wr_rsp_valid(wr_rsp_valid), .wr_rsp_err(wr_rsp_err)
   );

   logic [7:0]  mem [MEMSZ];
   int          n_chk = 0;
   int          n_bad = 0;
   int          nw;
   int          pat_bad;
   logic        seen_done, seen_err;
   logic [2:0]  seen_code;
   logic [31:0] seen_eaddr;

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic fill_mem();
      for (int i = 0; i < MEMSZ; i++) mem[i] = 8'hFF;
   endtask

   function automatic int midx(input logic [31:0] a);
      return int'(a % 32'(MEMSZ));
   endfunction

   task automatic serve(input int fault_at, input int merr_at, input logic [31:0] base, input logic [NB-1:0] strb);
      nw = 0; pat_bad = 0; seen_done = 1'b0; seen_err = 1'b0;
      seen_code = '0; seen_eaddr = '0;
      for (int i = 0; i < 8000 && !seen_done && !seen_err; i++) begin
         if (done) seen_done = 1'b1;
         if (err) begin
            seen_err = 1'b1; seen_code = err_code; seen_eaddr = err_addr;
         end
         xl_rsp_valid = xl_req_valid;
         xl_rsp_fault = xl_req_valid && (nw == fault_at);
         wr_ready     = wr_valid;
         if (wr_valid) begin
            if (wr_addr !== base + 32'(nw * NB) || wr_data !== '0 || wr_strb !== strb) pat_bad++;
            wr_rsp_err = (nw == merr_at);
            if (nw != merr_at)
               for (int b = 0; b < NB; b++)
                  if (wr_strb[b]) mem[midx(wr_addr + 32'(b))] = wr_data[8*b +: 8];
            nw++;
         end
         if (!seen_done && !seen_err) @(negedge clk);
      end
      xl_rsp_valid = 1'b0; xl_rsp_fault = 1'b0; wr_ready = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      logic [31:0]   aligned, base;
      logic [NB-1:0] strb;
      int            size, zbad;
      string         req;
      fill_mem();
      aligned = v.addr & ~((32'd1 << v.e) - 32'd1);
      base    = aligned & ~32'(NB - 1);
      size    = 1 << v.e;
      if (v.e >= 4'd2) strb = '1;
      else strb = NB'(((1 << (1 << v.e)) - 1) << aligned[1:0]);
      case (v.code)
         3'd1: req = "R2";
         3'd2: req = "R3";
         3'd3: req = "R7";
         3'd4: req = "R8";
         default: req = (v.e < 4'd2) ? "R6" : "R5";
      endcase
      @(negedge clk);
      start_addr = v.addr; start_exp = v.e; priv = v.pv;
      menv_zero_en = v.men; senv_zero_en = v.sen; smode_impl = v.smi;
      start_valid = 1'b1;
      @(negedge clk);
      start_valid = 1'b0;
      serve(v.fault_at, v.merr_at, base, strb);
      check("R10", "one outcome", 64'(seen_done) + 64'(seen_err), 64'd1);
      check(req, "outcome code", seen_err ? 64'(seen_code) : (seen_done ? 64'd0 : 64'd7), 64'(v.code));
      if (v.code != 3'd0) check("R7", "err_addr", 64'(seen_eaddr), 64'(v.addr));
      check(req, "write count", 64'(nw), 64'(v.nwr));
      if (v.nwr > 0) check("R4", "write addr/data/strb", 64'(pat_bad), 64'd0);
      if (v.code == 3'd0) begin
         zbad = 0;
         for (int i = 0; i < size; i++) if (mem[midx(aligned + 32'(i))] !== 8'h00) zbad++;
         check(req, "block zeroed", 64'(zbad), 64'd0);
         check("R6", "byte below block", 64'(mem[midx(aligned - 32'd1)]), 64'hFF);
         if (int'(aligned) + size < MEMSZ)
            check("R6", "byte above block", 64'(mem[midx(aligned + 32'(size))]), 64'hFF);
      end
      check("R9", "idle after end", {62'd0, busy, start_ready}, 64'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "outputs in reset",
            {58'd0, busy, done, err, wr_valid, xl_req_valid, start_ready}, 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "outputs after reset",
            {58'd0, busy, done, err, wr_valid, xl_req_valid, start_ready}, 64'd1);

      for (int k = 0; k < NV; k++) run_vec(VECS[k]);

      // R9: a start while busy is ignored; R10: done lasts one cycle
      fill_mem();
      @(negedge clk);
      start_addr = 32'h2300; start_exp = 4'd2; priv = 2'b11; start_valid = 1'b1;
      @(negedge clk);
      start_addr = 32'h2800;
      check("R9", "busy and not ready", {62'd0, busy, start_ready}, 64'd2);
      @(negedge clk);
      start_valid = 1'b0;
      serve(-1, -1, 32'h2300, '1);
      check("R9", "single op writes", 64'(nw), 64'd1);
      check("R9", "ignored start left memory", 64'(mem[midx(32'h2800)]), 64'hFF);
      check("R9", "first op completed", 64'(seen_done), 64'd1);
      @(negedge clk);
      check("R10", "done one cycle", 64'(done), 64'd0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R9", "no request while idle", {62'd0, wr_valid, xl_req_valid}, 64'd0);
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule